// File: doc/BRIEF.md
# Descriptor-Chained Display Layer Loader

This block is the configuration front end of one graphics display layer. The layer's settings do not come from software writes one register at a time. They sit in memory as descriptor nodes of sixteen 32-bit words, and each node carries the address of the node to use after it. Software normally builds two nodes that point at each other, one per video field. The loader then walks that pair forever, with no further software action.

On every vertical sync pulse the block reads the sixteen words of the pending node, one word at a time, over a simple word-read memory port. It keeps the words in a shadow store. Only after the last word has arrived does it move every field into the live configuration outputs in a single cycle. The node's link word then becomes the new pending pointer.

A small register port gives direct access to the live fields. It also accepts a new pending pointer, which is used only at the next vertical sync, and it returns the address of the node now in use. Sticky status flags report a late fetch, a misaligned pointer write and a pixel-buffer underflow. The block also latches a top/bottom field indication at every vertical sync.

Top module: `layer_desc_loader`

## Requirements
- R1: After reset every live configuration output is zero, `layer_visible` is low, the status register (word index 26, byte 0x68) reads zero, and the pointer register (byte 0x24) reads zero, meaning no chain is loaded. A vertical sync while the pending pointer is zero issues no memory read.
- R2: A vertical sync with a nonzero pending pointer P issues exactly 16 word reads, at P, P+4, … P+60, each on a word-aligned address. All fields change together in one cycle, after the 16th word returns. Word 9 of the node, with its low 4 bits forced to zero, becomes the new pending pointer.
- R3: Two nodes whose word 9 fields point at each other are committed alternately at successive vertical syncs. Reading byte 0x24 returns the address of the node most recently committed.
- R4: A write of an aligned value to byte 0x24 leaves the live configuration and the 0x24 readback unchanged until a node is fetched from the written address after the next vertical sync. A pointer written during a fetch is not overwritten by that fetch's link word.
- R5: A write to byte 0x24 whose low 4 bits are not all zero is ignored and sets status bit 2.
- R6: `layer_visible` is high only when a node has been committed and bits 1:0 of the mixer-control word (word 13, byte 0x34) are both zero.
- R7: The size word (word 7, byte 0x1C) holds height in bits 31:16 and width in bits 15:0. A committed or directly written width above 3840 is stored as 3840, and a height above 2160 is stored as 2160.
- R8: If a vertical sync arrives while a fetch is still in progress, the live configuration is kept and status bit 1 is set. The fetch restarts from the pending pointer, and the restarted node commits once memory responds.
- R9: A pulse on `underflow` sets status bit 0. Writing a one to any status bit clears that bit, and bits written with zero keep their value.
- R10: `cfg_field_top` takes the value of `field_top` sampled at each vertical sync.
- R11: A register write to a live field at byte offsets 0x00, 0x04, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x28, 0x2C, 0x34 or 0x3C reads back on the next cycle. Writes to reserved offsets 0x08, 0x20, 0x30 and 0x38 are ignored, and those offsets read zero.
- R12: `cfg_fmt` is bits 4:0 of the control word (word 0) and `cfg_wait_vsync` is bit 31 of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | One-cycle vertical sync pulse |
| field_top | input | 1 | High when the coming field is the top field |
| underflow | input | 1 | Pixel-buffer underflow pulse from the pixel path |
| mem_rd | output | 1 | Word read request, one cycle per word |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cfg_ctl | output | 32 | Live control word |
| cfg_alpha | output | 32 | Live alpha gain |
| cfg_org | output | 32 | Live viewport origin (line 31:16, pixel 15:0) |
| cfg_stop | output | 32 | Live viewport stop (line 31:16, pixel 15:0) |
| cfg_pix_addr | output | 32 | Live pixel memory address |
| cfg_pitch | output | 32 | Live line pitch |
| cfg_size | output | 32 | Live size (height 31:16, width 15:0), clamped |
| cfg_key1 | output | 32 | Live colour key 1 |
| cfg_key2 | output | 32 | Live colour key 2 |
| cfg_mix | output | 32 | Live mixer-control word |
| cfg_clut | output | 32 | Live colour lookup address |
| cfg_fmt | output | 5 | Pixel format code |
| cfg_wait_vsync | output | 1 | Wait-for-next-vsync flag |
| layer_visible | output | 1 | Layer shown to the mixer |
| cfg_field_top | output | 1 | Field indication latched at the last vsync |
| cfg_commit | output | 1 | High in the first cycle a newly fetched node is live |

## Verification
A wrong fetch counter or base address shows at the memory port on the first read after a vertical sync. It also shows one field later as a wrong readback at 0x24, or as the two nodes of a pair no longer alternating. A shadow-store or commit fault shows as fields changing before `cfg_commit` or as a mixture of two nodes; the bench catches this by probing the outputs a few cycles into a fetch and again once it completes. Faults in the restart and drain path after a late vertical sync stay hidden until memory stalls, so the bench holds memory back across a second sync and then checks that the intended node still lands.

// File: rtl/ldl_pkg.sv
package ldl_pkg;

    localparam int WORD_W     = 32;
    localparam int NODE_WORDS = 16;
    localparam int IDX_W      = $clog2(NODE_WORDS);
    localparam int ALIGN_BITS = 4;

    // word positions inside a node; the register port uses the same index
    localparam int IDX_CTL    = 0;
    localparam int IDX_ALPHA  = 1;
    localparam int IDX_ORG    = 3;
    localparam int IDX_STOP   = 4;
    localparam int IDX_PIX    = 5;
    localparam int IDX_PITCH  = 6;
    localparam int IDX_SIZE   = 7;
    localparam int IDX_NEXT   = 9;
    localparam int IDX_KEY1   = 10;
    localparam int IDX_KEY2   = 11;
    localparam int IDX_MIX    = 13;
    localparam int IDX_CLUT   = 15;
    localparam int STATUS_IDX = 26;

    // status flag positions
    localparam int ST_UNDERFLOW = 0;
    localparam int ST_LATE      = 1;
    localparam int ST_BADPTR    = 2;
    localparam int ST_W         = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [NODE_WORDS-1:0] node_t;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_ISSUE,
        FS_WAIT,
        FS_DRAIN
    } fetch_state_e;

    function automatic logic is_reserved(int idx);
        return (idx == 2) || (idx == 8) || (idx == 12) || (idx == 14);
    endfunction

    function automatic word_t clamp_size(word_t w, int unsigned max_w, int unsigned max_h);
        logic [15:0] wd;
        logic [15:0] ht;
        wd = w[15:0];
        ht = w[31:16];
        if (wd > 16'(max_w)) wd = 16'(max_w);
        if (ht > 16'(max_h)) ht = 16'(max_h);
        return {ht, wd};
    endfunction

endpackage

// File: rtl/ldl_fetch_seq.sv
module ldl_fetch_seq
    import ldl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  word_t             mem_rdata_i,
    output logic              busy_o,
    output logic              late_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] node_addr_o,
    output node_t             node_o
);

    localparam int CNT_W = IDX_W;

    fetch_state_e      st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] base_q;
    logic              restart_q;
    node_t             shadow_q;

    logic have_base;
    logic last_word;

    assign have_base   = (base_i != '0);
    assign last_word   = (cnt_q == CNT_W'(NODE_WORDS - 1));
    assign busy_o      = (st_q != FS_IDLE);
    assign late_o      = start_i && busy_o;
    assign done_o      = (st_q == FS_WAIT) && mem_rvalid_i && last_word && !start_i;
    assign mem_rd_o    = (st_q == FS_ISSUE);
    assign mem_addr_o  = base_q + ADDR_W'({cnt_q, 2'b00});
    assign node_addr_o = base_q;

    // the last word is taken straight from the bus so the commit costs no extra cycle
    for (genvar i = 0; i < NODE_WORDS; i++) begin : g_node
        if (i == NODE_WORDS - 1) begin : g_bus
            assign node_o[i] = mem_rdata_i;
        end else begin : g_shd
            assign node_o[i] = shadow_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= FS_IDLE;
            cnt_q     <= '0;
            base_q    <= '0;
            restart_q <= 1'b0;
            shadow_q  <= '0;
        end else begin
            if (st_q == FS_WAIT && mem_rvalid_i && !start_i) begin
                shadow_q[cnt_q] <= mem_rdata_i;
            end
            case (st_q)
                FS_IDLE: begin
                    if (start_i && have_base) begin
                        base_q <= base_i;
                        cnt_q  <= '0;
                        st_q   <= FS_ISSUE;
                    end
                end
                FS_ISSUE: begin
                    if (start_i) begin
                        // a request leaves this cycle, so its answer must be drained
                        restart_q <= have_base;
                        if (have_base) base_q <= base_i;
                        cnt_q <= '0;
                        st_q  <= FS_DRAIN;
                    end else begin
                        st_q <= FS_WAIT;
                    end
                end
                FS_WAIT: begin
                    if (start_i) begin
                        restart_q <= have_base;
                        if (have_base) base_q <= base_i;
                        cnt_q <= '0;
                        if (mem_rvalid_i) st_q <= have_base ? FS_ISSUE : FS_IDLE;
                        else              st_q <= FS_DRAIN;
                    end else if (mem_rvalid_i) begin
                        if (last_word) begin
                            cnt_q <= '0;
                            st_q  <= FS_IDLE;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                            st_q  <= FS_ISSUE;
                        end
                    end
                end
                FS_DRAIN: begin
                    if (start_i) begin
                        restart_q <= have_base;
                        if (have_base) base_q <= base_i;
                    end
                    if (mem_rvalid_i) begin
                        if (start_i ? have_base : restart_q) st_q <= FS_ISSUE;
                        else                                  st_q <= FS_IDLE;
                    end
                end
                default: st_q <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ldl_cfg_bank.sv
module ldl_cfg_bank
    import ldl_pkg::*;
#(
    parameter int unsigned MAX_WIDTH  = 3840,
    parameter int unsigned MAX_HEIGHT = 2160,
    parameter int          REG_IDX_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 commit_i,
    input  node_t                node_i,
    input  logic                 wr_en_i,
    input  logic [REG_IDX_W-1:0] wr_idx_i,
    input  word_t                wr_data_i,
    output node_t                cfg_o
);

    for (genvar i = 0; i < NODE_WORDS; i++) begin : g_word
        if (is_reserved(i) || i == IDX_NEXT) begin : g_hole
            assign cfg_o[i] = '0;
        end else begin : g_live
            word_t q;
            word_t commit_val;
            word_t wr_val;
            if (i == IDX_SIZE) begin : g_clamp
                assign commit_val = clamp_size(node_i[i], MAX_WIDTH, MAX_HEIGHT);
                assign wr_val     = clamp_size(wr_data_i, MAX_WIDTH, MAX_HEIGHT);
            end else begin : g_plain
                assign commit_val = node_i[i];
                assign wr_val     = wr_data_i;
            end
            // a node commit takes precedence over a register write in the same cycle
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (commit_i) begin
                    q <= commit_val;
                end else if (wr_en_i && wr_idx_i == REG_IDX_W'(i)) begin
                    q <= wr_val;
                end
            end
            assign cfg_o[i] = q;
        end
    end

endmodule

// File: rtl/ldl_status.sv
module ldl_status
    import ldl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] set_i,
    input  logic [ST_W-1:0] clr_i,
    output logic [ST_W-1:0] flags_o
);

    logic [ST_W-1:0] flags_q;

    // a new event wins over a clear arriving in the same cycle
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/layer_desc_loader.sv
module layer_desc_loader
    import ldl_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          REG_AW     = 7,
    parameter int unsigned MAX_WIDTH  = 3840,
    parameter int unsigned MAX_HEIGHT = 2160
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vsync,
    input  logic              field_top,
    input  logic              underflow,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [31:0]       cfg_ctl,
    output logic [31:0]       cfg_alpha,
    output logic [31:0]       cfg_org,
    output logic [31:0]       cfg_stop,
    output logic [31:0]       cfg_pix_addr,
    output logic [31:0]       cfg_pitch,
    output logic [31:0]       cfg_size,
    output logic [31:0]       cfg_key1,
    output logic [31:0]       cfg_key2,
    output logic [31:0]       cfg_mix,
    output logic [31:0]       cfg_clut,
    output logic [4:0]        cfg_fmt,
    output logic              cfg_wait_vsync,
    output logic              layer_visible,
    output logic              cfg_field_top,
    output logic              cfg_commit
);

    localparam int REG_IDX_W = REG_AW - 2;
    localparam logic [REG_IDX_W-1:0] RI_NEXT   = REG_IDX_W'(IDX_NEXT);
    localparam logic [REG_IDX_W-1:0] RI_STATUS = REG_IDX_W'(STATUS_IDX);
    localparam logic [REG_IDX_W-1:0] RI_NODES  = REG_IDX_W'(NODE_WORDS);

    logic [REG_IDX_W-1:0] reg_idx;
    logic                 ptr_sel;
    logic                 ptr_aligned;
    logic                 field_wr;

    logic              fetch_busy;
    logic              fetch_late;
    logic              fetch_done;
    logic [ADDR_W-1:0] fetch_node_addr;
    node_t             fetch_node;
    node_t             cfg;

    logic [ADDR_W-1:0] next_ptr_q;
    logic [ADDR_W-1:0] cur_node_q;
    logic              ptr_written_q;
    logic              loaded_q;
    logic              field_q;
    logic              commit_q;

    logic [ST_W-1:0]   status_set;
    logic [ST_W-1:0]   status_clr;
    logic [ST_W-1:0]   status_q;

    assign reg_idx     = reg_addr[REG_AW-1:2];
    assign ptr_sel     = reg_wen && (reg_idx == RI_NEXT);
    assign ptr_aligned = (reg_wdata[ALIGN_BITS-1:0] == '0);
    assign field_wr    = reg_wen && (reg_idx < RI_NODES) && (reg_idx != RI_NEXT);

    ldl_fetch_seq #(
        .ADDR_W (ADDR_W)
    ) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .start_i      (vsync),
        .base_i       (next_ptr_q),
        .mem_rd_o     (mem_rd),
        .mem_addr_o   (mem_addr),
        .mem_rvalid_i (mem_rvalid),
        .mem_rdata_i  (mem_rdata),
        .busy_o       (fetch_busy),
        .late_o       (fetch_late),
        .done_o       (fetch_done),
        .node_addr_o  (fetch_node_addr),
        .node_o       (fetch_node)
    );

    ldl_cfg_bank #(
        .MAX_WIDTH  (MAX_WIDTH),
        .MAX_HEIGHT (MAX_HEIGHT),
        .REG_IDX_W  (REG_IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .commit_i  (fetch_done),
        .node_i    (fetch_node),
        .wr_en_i   (field_wr),
        .wr_idx_i  (reg_idx),
        .wr_data_i (reg_wdata),
        .cfg_o     (cfg)
    );

    always_comb begin
        status_set               = '0;
        status_set[ST_UNDERFLOW] = underflow;
        status_set[ST_LATE]      = fetch_late;
        status_set[ST_BADPTR]    = ptr_sel && !ptr_aligned;
        status_clr = (reg_wen && reg_idx == RI_STATUS) ? reg_wdata[ST_W-1:0] : '0;
    end

    ldl_status u_status (
        .clk     (clk),
        .rst     (rst),
        .set_i   (status_set),
        .clr_i   (status_clr),
        .flags_o (status_q)
    );

    // chain pointer bookkeeping: pending pointer, node in use, field latch
    always_ff @(posedge clk) begin
        if (rst) begin
            next_ptr_q    <= '0;
            cur_node_q    <= '0;
            ptr_written_q <= 1'b0;
            loaded_q      <= 1'b0;
            field_q       <= 1'b0;
            commit_q      <= 1'b0;
        end else begin
            commit_q <= fetch_done;
            if (vsync) field_q <= field_top;
            if (fetch_done) begin
                cur_node_q <= fetch_node_addr;
                loaded_q   <= 1'b1;
            end
            if (ptr_sel && ptr_aligned) begin
                next_ptr_q    <= ADDR_W'(reg_wdata);
                ptr_written_q <= 1'b1;
            end else begin
                if (fetch_done && !ptr_written_q) begin
                    next_ptr_q <= ADDR_W'(fetch_node[IDX_NEXT] >> ALIGN_BITS) << ALIGN_BITS;
                end
                if (vsync) ptr_written_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_idx == RI_STATUS) begin
            reg_rdata = 32'(status_q);
        end else if (reg_idx == RI_NEXT) begin
            reg_rdata = 32'(cur_node_q);
        end else if (reg_idx < RI_NODES) begin
            reg_rdata = cfg[reg_idx[IDX_W-1:0]];
        end
    end

    assign cfg_ctl        = cfg[IDX_CTL];
    assign cfg_alpha      = cfg[IDX_ALPHA];
    assign cfg_org        = cfg[IDX_ORG];
    assign cfg_stop       = cfg[IDX_STOP];
    assign cfg_pix_addr   = cfg[IDX_PIX];
    assign cfg_pitch      = cfg[IDX_PITCH];
    assign cfg_size       = cfg[IDX_SIZE];
    assign cfg_key1       = cfg[IDX_KEY1];
    assign cfg_key2       = cfg[IDX_KEY2];
    assign cfg_mix        = cfg[IDX_MIX];
    assign cfg_clut       = cfg[IDX_CLUT];
    assign cfg_fmt        = cfg[IDX_CTL][4:0];
    assign cfg_wait_vsync = cfg[IDX_CTL][31];
    assign layer_visible  = loaded_q && (cfg[IDX_MIX][1:0] == 2'b00);
    assign cfg_field_top  = field_q;
    assign cfg_commit     = commit_q;

endmodule

// File: rtl/ldl_checker.sv
module ldl_checker
    import ldl_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          REG_AW     = 7,
    parameter int unsigned MAX_WIDTH  = 3840,
    parameter int unsigned MAX_HEIGHT = 2160
) (
    input logic              clk,
    input logic              rst,
    input logic              vsync,
    input logic              underflow,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              reg_wen,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              fetch_busy,
    input logic              fetch_done,
    input logic [31:0]       cfg_size,
    input logic [31:0]       cfg_mix,
    input logic [31:0]       cfg_pix_addr,
    input logic              layer_visible,
    input logic [ST_W-1:0]   status
);

    // R2
    mem_addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr[1:0] == 2'b00));

    // R7
    size_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_size[15:0] <= 16'(MAX_WIDTH)) && (cfg_size[31:16] <= 16'(MAX_HEIGHT)));

    // R6
    hidden_layer_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mix[1:0] != 2'b00) |-> !layer_visible);

    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fetch_done && !reg_wen) |=> $stable(cfg_pix_addr));

    // R5
    bad_ptr_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && reg_addr[REG_AW-1:2] == (REG_AW-2)'(IDX_NEXT) && reg_wdata[ALIGN_BITS-1:0] != '0)
        |=> status[ST_BADPTR]);

    // R8
    late_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (vsync && fetch_busy) |=> status[ST_LATE]);

    // R9
    underflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |=> status[ST_UNDERFLOW]);

endmodule

bind layer_desc_loader ldl_checker #(
    .ADDR_W     (ADDR_W),
    .REG_AW     (REG_AW),
    .MAX_WIDTH  (MAX_WIDTH),
    .MAX_HEIGHT (MAX_HEIGHT)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .vsync         (vsync),
    .underflow     (underflow),
    .mem_rd        (mem_rd),
    .mem_addr      (mem_addr),
    .reg_wen       (reg_wen),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .fetch_busy    (fetch_busy),
    .fetch_done    (fetch_done),
    .cfg_size      (cfg_size),
    .cfg_mix       (cfg_mix),
    .cfg_pix_addr  (cfg_pix_addr),
    .layer_visible (layer_visible),
    .status        (status_q)
);

// File: tb/layer_desc_loader_tb.sv
`timescale 1ns/1ps
module layer_desc_loader_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vsync = 1'b0;
    logic        field_top = 1'b0;
    logic        underflow = 1'b0;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        reg_wen = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] cfg_ctl, cfg_alpha, cfg_org, cfg_stop, cfg_pix_addr, cfg_pitch;
    logic [31:0] cfg_size, cfg_key1, cfg_key2, cfg_mix, cfg_clut;
    logic [4:0]  cfg_fmt;
    logic        cfg_wait_vsync, layer_visible, cfg_field_top, cfg_commit;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    layer_desc_loader u_dut (
        .clk(clk), .rst(rst), .vsync(vsync), .field_top(field_top), .underflow(underflow),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_ctl(cfg_ctl), .cfg_alpha(cfg_alpha), .cfg_org(cfg_org), .cfg_stop(cfg_stop),
        .cfg_pix_addr(cfg_pix_addr), .cfg_pitch(cfg_pitch), .cfg_size(cfg_size),
        .cfg_key1(cfg_key1), .cfg_key2(cfg_key2), .cfg_mix(cfg_mix), .cfg_clut(cfg_clut),
        .cfg_fmt(cfg_fmt), .cfg_wait_vsync(cfg_wait_vsync), .layer_visible(layer_visible),
        .cfg_field_top(cfg_field_top), .cfg_commit(cfg_commit)
    );

    // memory model: 64 words, answer two cycles after a request unless stalled
    logic [31:0] mem [64];
    logic        stall = 1'b0;
    logic        pend = 1'b0;
    logic [31:0] paddr = '0;
    int          rd_cnt = 0;
    logic [31:0] last_addr = '0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_rd) begin
            pend      <= 1'b1;
            paddr     <= mem_addr;
            rd_cnt    <= rd_cnt + 1;
            last_addr <= mem_addr;
        end else if (pend && !stall) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[paddr[7:2]];
            pend       <= 1'b0;
        end
    end

    // register vectors: {byte address, write data, expected readback}
    localparam logic [95:0] VEC [8] = '{
        {32'h04, 32'h0080_8080, 32'h0080_8080},
        {32'h0C, 32'h0010_0020, 32'h0010_0020},
        {32'h10, 32'h0100_0200, 32'h0100_0200},
        {32'h1C, 32'hFFFF_FFFF, 32'h0870_0F00},
        {32'h1C, 32'h0870_0F00, 32'h0870_0F00},
        {32'h08, 32'hDEAD_BEEF, 32'h0000_0000},
        {32'h34, 32'h0000_0001, 32'h0000_0001},
        {32'h3C, 32'h1234_5670, 32'h1234_5670}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse_vs(input logic ft);
        @(negedge clk);
        vsync = 1'b1; field_top = ft;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic mk_node(input int base, input logic [7:0] tag, input logic [31:0] ctl,
                           input logic [31:0] size, input logic [31:0] nxt, input logic [31:0] mix);
        for (int k = 0; k < 16; k++) mem[base/4 + k] = {tag, 16'h0, 8'(k)};
        mem[base/4 + 0]  = ctl;
        mem[base/4 + 5]  = {tag, 24'h5};
        mem[base/4 + 7]  = size;
        mem[base/4 + 9]  = nxt;
        mem[base/4 + 13] = mix;
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int snap;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mk_node(32'h40, 8'hA0, 32'h8000_0005, 32'h0100_0200, 32'h80, 32'h0);
        mk_node(32'h80, 8'hB0, 32'h0000_0007, 32'h0050_0060, 32'h40, 32'h0);
        mk_node(32'hC0, 8'hC0, 32'h0000_0001, 32'hFFFF_FFFF, 32'hC4, 32'h2);

        idle(4);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        chk("R1 visible", 32'(layer_visible), 32'h0);
        chk("R1 pix", cfg_pix_addr, 32'h0);
        rd(7'h24, d); chk("R1 ptr", d, 32'h0);
        rd(7'h68, d); chk("R1 status", d, 32'h0);
        snap = rd_cnt;
        pulse_vs(1'b0);
        idle(10);
        chk("R1 no fetch", 32'(rd_cnt - snap), 32'h0);

        // R11 and R7 through the register vectors
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][70:64], VEC[i][63:32]);
            rd(VEC[i][70:64], d);
            chk("R11 vec", d, VEC[i][31:0]);
        end
        chk("R7 size port", cfg_size, 32'h0870_0F00);
        chk("R6 not loaded", 32'(layer_visible), 32'h0);

        // R4 pointer write takes no effect before vsync
        wr(7'h24, 32'h40);
        idle(3);
        rd(7'h24, d); chk("R4 ptr readback", d, 32'h0);
        chk("R4 pix hold", cfg_pix_addr, 32'h0);

        snap = rd_cnt;
        pulse_vs(1'b1);
        chk("R10 field top", 32'(cfg_field_top), 32'h1);
        idle(4);
        chk("R2 mid fetch hold", cfg_pix_addr, 32'h0);
        idle(100);
        chk("R2 read count", 32'(rd_cnt - snap), 32'd16);
        chk("R2 last addr", last_addr, 32'h40 + 32'd60);
        chk("R2 pix", cfg_pix_addr, 32'hA000_0005);
        chk("R2 key2", cfg_key2, 32'hA000_000B);
        chk("R12 fmt", 32'(cfg_fmt), 32'h5);
        chk("R12 wait", 32'(cfg_wait_vsync), 32'h1);
        chk("R6 visible", 32'(layer_visible), 32'h1);
        rd(7'h24, d); chk("R3 node A", d, 32'h40);

        // R3 alternation
        pulse_vs(1'b0);
        chk("R10 field bottom", 32'(cfg_field_top), 32'h0);
        idle(100);
        rd(7'h24, d); chk("R3 node B", d, 32'h80);
        chk("R3 pix B", cfg_pix_addr, 32'hB000_0005);
        chk("R12 fmt B", 32'(cfg_fmt), 32'h7);
        chk("R12 wait B", 32'(cfg_wait_vsync), 32'h0);
        pulse_vs(1'b1);
        idle(100);
        rd(7'h24, d); chk("R3 back to A", d, 32'h40);

        // R5 misaligned pointer ignored
        wr(7'h24, 32'h44);
        rd(7'h68, d); chk("R5 flag", d, 32'h4);
        pulse_vs(1'b0);
        idle(100);
        rd(7'h24, d); chk("R5 chain kept", d, 32'h80);
        wr(7'h68, 32'h4);
        rd(7'h68, d); chk("R9 clear bit2", d, 32'h0);

        // R6 and R7 with a hidden self-linked node
        wr(7'h24, 32'hC0);
        pulse_vs(1'b1);
        idle(100);
        chk("R6 hidden", 32'(layer_visible), 32'h0);
        chk("R7 clamp", cfg_size, 32'h0870_0F00);
        rd(7'h24, d); chk("R3 node C", d, 32'hC0);
        snap = rd_cnt;
        pulse_vs(1'b0);
        idle(100);
        chk("R2 masked link", last_addr, 32'hC0 + 32'd60);
        chk("R2 count C", 32'(rd_cnt - snap), 32'd16);

        // R8 late fetch
        wr(7'h24, 32'h40);
        stall = 1'b1;
        pulse_vs(1'b1);
        idle(20);
        pulse_vs(1'b0);
        rd(7'h68, d); chk("R8 late flag", d, 32'h2);
        chk("R8 config kept", cfg_pix_addr, 32'hC000_0005);
        stall = 1'b0;
        idle(100);
        chk("R8 restarted", cfg_pix_addr, 32'hA000_0005);
        rd(7'h24, d); chk("R8 node", d, 32'h40);

        // R9 underflow and write-one-to-clear
        @(negedge clk); underflow = 1'b1;
        @(negedge clk); underflow = 1'b0;
        rd(7'h68, d); chk("R9 underflow", d, 32'h3);
        wr(7'h68, 32'h1);
        rd(7'h68, d); chk("R9 clear bit0", d, 32'h2);
        wr(7'h68, 32'h2);
        rd(7'h68, d); chk("R9 clear bit1", d, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule